// File: doc/BRIEF.md
# Delayed-Commit Trace Coprocessor Register Port

This block is the receiving end of a narrow coprocessor channel. A processor core uses the channel to hand trace-related register accesses to a trace unit. A transfer begins with an enable strobe, which carries a direction flag and a 15-bit register number. Exactly two cycles later the core presents a commit strobe and a 32-bit write value. A committed write updates one register in a small local bank. A transfer whose commit strobe is low is dropped without any effect.

Transfers may overlap: the last cycle of one transfer can be the first cycle of the next, so one transfer can start every two cycles. The block therefore holds the direction and register number of each transfer in a two-deep pipeline until that transfer's commit cycle. The read-data return path is tied to zero.

The bank contents are presented on outputs to the rest of the trace unit. The bank holds a set of configuration registers in the CP14 space and one context-identifier register in the CP15 space.

Top module: `trc_cp_port`

## Requirements
- R1: The direction flag and register number are taken only in the cycle the enable strobe is high. Changes to `cp_wr` or `cp_addr` in the cycles after that have no effect on the pending transfer.
- R2: The commit strobe and the write value are sampled exactly two cycles after the enable. A committed write is visible on the bank outputs after that clock edge and not before.
- R3: If the commit strobe is low two cycles after an enable, the transfer is cancelled and no register changes.
- R4: Enables spaced two cycles apart, with each commit cycle coinciding with the next enable, are each applied to their own register with their own data and commit decision.
- R5: `cp_rdata` is zero at all times.
- R6: Address bit 14 selects the space: 0 for CP14, 1 for CP15. CP14 numbers 0 to NREG-1 (bits 13:0) select configuration register n on `cfg_q[32n+31:32n]`. CP15 number 0 (address 0x4000) selects the context identifier on `ctxid_q`.
- R7: A committed write to any other register number (for example CP14 number NREG, or CP15 number 1) is discarded with no error, and every register keeps its value.
- R8: A committed read (`cp_wr` low at enable) leaves every register unchanged.
- R9: After reset, every configuration register and the context identifier are zero.
- R10: A commit strobe that arrives with no enable two cycles earlier has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cp_en | input | 1 | Transfer enable strobe; qualifies cp_wr and cp_addr |
| cp_wr | input | 1 | 1 for write, 0 for read |
| cp_addr | input | 15 | Register number; bit 14 selects the space |
| cp_commit | input | 1 | Commit strobe, two cycles after the enable |
| cp_wdata | input | 32 | Write value, two cycles after the enable |
| cp_rdata | output | 32 | Read data, constant zero |
| cfg_q | output | 32*NREG | Configuration register contents, register n in bits 32n+31:32n |
| ctxid_q | output | 32 | Context identifier register contents |

## Verification
The hardest case to reach is a cancelled or read transfer that is still pending while the next enable arrives in its commit cycle. In that case the pipeline must keep the two transfers' addresses and decisions apart. A directed task builds this overlap on purpose with one committed and one cancelled transfer. A randomized run of enables spaced two cycles apart then mixes commit values, directions and unimplemented register numbers, and compares the whole bank with a model after every cycle. A separate task changes the address and direction in the cycles after an enable, which shows that only the enable-cycle values count.

// File: rtl/trc_cp_pkg.sv
package trc_cp_pkg;
  localparam int ADDR_W    = 15;
  localparam int DATA_W    = 32;
  localparam int SPACE_BIT = ADDR_W - 1;
  localparam int NUM_W     = ADDR_W - 1;
  localparam int CTX_NUM   = 0;

  typedef struct packed {
    logic              valid;
    logic              wr;
    logic [ADDR_W-1:0] addr;
  } cp_req_t;
endpackage

// File: rtl/trc_cp_pipe.sv
module trc_cp_pipe
  import trc_cp_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  cp_req_t in_req,
  output cp_req_t out_req
);
  cp_req_t [DEPTH-1:0] stg_q;
  cp_req_t [DEPTH-1:0] stg_d;
  logic                adv;

  // next-state: shift toward the commit stage
  always_comb begin
    stg_d[0] = in_req;
    for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
    adv = in_req.valid;
    for (int i = 0; i < DEPTH; i++) adv = adv | stg_q[i].valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else if (adv) begin
      stg_q <= stg_d;
    end
  end

  assign out_req = stg_q[DEPTH-1];
endmodule

// File: rtl/trc_cp_dec.sv
module trc_cp_dec
  import trc_cp_pkg::*;
#(
  parameter int NREG = 8
) (
  input  cp_req_t         req,
  input  logic            commit,
  output logic [NREG-1:0] cfg_we,
  output logic            ctx_we
);
  logic             go;
  logic [NUM_W-1:0] num;
  logic             space;

  assign go    = req.valid & req.wr & commit;
  assign num   = req.addr[NUM_W-1:0];
  assign space = req.addr[SPACE_BIT];

  for (genvar g = 0; g < NREG; g++) begin : g_we
    assign cfg_we[g] = go & ~space & (num == NUM_W'(g));
  end

  assign ctx_we = go & space & (num == NUM_W'(CTX_NUM));
endmodule

// File: rtl/trc_cp_bank.sv
module trc_cp_bank
  import trc_cp_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NREG-1:0]        cfg_we,
  input  logic                   ctx_we,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NREG*DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0]      ctx_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    logic [DATA_W-1:0] r_d;

    always_comb r_d = wdata;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= '0;
      end else if (cfg_we[g]) begin
        r_q <= r_d;
      end
    end

    assign cfg_q[g*DATA_W +: DATA_W] = r_q;
  end

  logic [DATA_W-1:0] ctx_d;
  always_comb ctx_d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '0;
    end else if (ctx_we) begin
      ctx_q <= ctx_d;
    end
  end
endmodule

// File: rtl/trc_cp_port.sv
module trc_cp_port
  import trc_cp_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cp_en,
  input  logic                   cp_wr,
  input  logic [14:0]            cp_addr,
  input  logic                   cp_commit,
  input  logic [31:0]            cp_wdata,
  output logic [31:0]            cp_rdata,
  output logic [NREG*32-1:0]     cfg_q,
  output logic [31:0]            ctxid_q
);
  localparam int COMMIT_LAT = 2;

  cp_req_t         req_in;
  cp_req_t         req_due;
  logic [NREG-1:0] cfg_we;
  logic            ctx_we;

  assign req_in.valid = cp_en;
  assign req_in.wr    = cp_wr;
  assign req_in.addr  = cp_addr;

  trc_cp_pipe #(.DEPTH(COMMIT_LAT)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_req  (req_in),
    .out_req (req_due)
  );

  trc_cp_dec #(.NREG(NREG)) u_dec (
    .req    (req_due),
    .commit (cp_commit),
    .cfg_we (cfg_we),
    .ctx_we (ctx_we)
  );

  trc_cp_bank #(.NREG(NREG)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_we (cfg_we),
    .ctx_we (ctx_we),
    .wdata  (cp_wdata),
    .cfg_q  (cfg_q),
    .ctx_q  (ctxid_q)
  );

  assign cp_rdata = '0;
endmodule

// File: rtl/trc_cp_port_chk.sv
module trc_cp_port_chk #(
  parameter int NREG = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cp_en,
  input logic               cp_wr,
  input logic [14:0]        cp_addr,
  input logic               cp_commit,
  input logic [31:0]        cp_wdata,
  input logic [31:0]        cp_rdata,
  input logic [NREG*32-1:0] cfg_q,
  input logic [31:0]        ctxid_q
);
  // R5
  rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_rdata == 32'h0);

  // R3
  cancel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cp_en, 2) && !cp_commit) |=> $stable({cfg_q, ctxid_q}));

  // R8
  read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cp_en, 2) && !$past(cp_wr, 2)) |=> $stable({cfg_q, ctxid_q}));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cp_en, 2) |=> $stable({cfg_q, ctxid_q}));

  // R2
  ctx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cp_en, 2) && $past(cp_wr, 2) && cp_commit && ($past(cp_addr, 2) == 15'h4000))
    |=> (ctxid_q == $past(cp_wdata)));
endmodule

bind trc_cp_port trc_cp_port_chk #(.NREG(NREG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cp_en     (cp_en),
  .cp_wr     (cp_wr),
  .cp_addr   (cp_addr),
  .cp_commit (cp_commit),
  .cp_wdata  (cp_wdata),
  .cp_rdata  (cp_rdata),
  .cfg_q     (cfg_q),
  .ctxid_q   (ctxid_q)
);

// File: tb/sim_trc_cp_port.sv
module sim_trc_cp_port;
  localparam int NREG = 8;
  localparam logic [14:0] CTX_A = 15'h4000;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cp_en, cp_wr, cp_commit;
  logic [14:0]        cp_addr;
  logic [31:0]        cp_wdata;
  logic [31:0]        cp_rdata;
  logic [NREG*32-1:0] cfg_q;
  logic [31:0]        ctxid_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_cfg [NREG];
  logic [31:0] m_ctx;
  logic        p1_v, p1_wr, p2_v, p2_wr;
  logic [14:0] p1_a, p2_a;

  always #5 clk = ~clk;

  trc_cp_port #(.NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .cp_en(cp_en), .cp_wr(cp_wr), .cp_addr(cp_addr),
    .cp_commit(cp_commit), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
    .cfg_q(cfg_q), .ctxid_q(ctxid_q)
  );

  task automatic model_write(input logic [14:0] a, input logic [31:0] d);
    if (!a[14] && (a[13:0] < 14'(NREG))) m_cfg[a[2:0]] = d;
    else if (a == CTX_A) m_ctx = d;
  endtask

  // one clock: drive at negedge, update model, sample 2 ns after posedge
  task automatic cyc(input logic en, input logic wr, input logic [14:0] a,
                     input logic cm, input logic [31:0] d);
    @(negedge clk);
    cp_en = en; cp_wr = wr; cp_addr = a; cp_commit = cm; cp_wdata = d;
    if (p2_v && p2_wr && cm) model_write(p2_a, d);
    p2_v = p1_v; p2_wr = p1_wr; p2_a = p1_a;
    p1_v = en;   p1_wr = wr;    p1_a = a;
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 15'h0, 1'b0, 32'h0);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < NREG; i++)
      chk(tag, $sformatf("cfg%0d", i), cfg_q[i*32 +: 32], m_cfg[i]);
    chk(tag, "ctxid", ctxid_q, m_ctx);
    chk(tag, "rdata", cp_rdata, 32'h0);
  endtask

  task automatic t_reset;
    check_bank("R9");
    chk("R5", "rdata after reset", cp_rdata, 32'h0);
  endtask

  task automatic t_single;
    for (int r = 0; r < NREG; r++) begin
      cyc(1'b1, 1'b1, 15'(r), 1'b0, 32'h0);
      check_bank("R2");
      cyc(1'b0, 1'b0, 15'h0, 1'b0, 32'h0);
      check_bank("R2");
      cyc(1'b0, 1'b0, 15'h0, 1'b1, 32'hA500_0000 + 32'(r));
      check_bank("R6");
    end
    cyc(1'b1, 1'b1, CTX_A, 1'b0, 32'h0);
    idle(1);
    cyc(1'b0, 1'b0, 15'h0, 1'b1, 32'hC0DE_1234);
    check_bank("R6");
    chk("R6", "ctxid value", ctxid_q, 32'hC0DE_1234);
  endtask

  task automatic t_cancel;
    cyc(1'b1, 1'b1, 15'd3, 1'b0, 32'h0);
    idle(1);
    cyc(1'b0, 1'b0, 15'h0, 1'b0, 32'hDEAD_BEEF);
    check_bank("R3");
    chk("R3", "cfg3 kept", cfg_q[3*32 +: 32], 32'hA500_0003);
  endtask

  task automatic t_overlap;
    cyc(1'b1, 1'b1, 15'd1, 1'b0, 32'h0);
    cyc(1'b0, 1'b0, 15'h0, 1'b0, 32'h0);
    cyc(1'b1, 1'b1, 15'd2, 1'b1, 32'h1111_0001);
    check_bank("R4");
    cyc(1'b0, 1'b0, 15'h0, 1'b0, 32'h0);
    cyc(1'b1, 1'b1, 15'd4, 1'b0, 32'h2222_0002);
    check_bank("R4");
    cyc(1'b0, 1'b0, 15'h0, 1'b0, 32'h0);
    cyc(1'b0, 1'b0, 15'h0, 1'b1, 32'h3333_0004);
    check_bank("R4");
    chk("R4", "cfg2 cancelled", cfg_q[2*32 +: 32], 32'hA500_0002);
    chk("R4", "cfg4 written", cfg_q[4*32 +: 32], 32'h3333_0004);
  endtask

  task automatic t_hold;
    // R1: address and direction move after the enable cycle
    cyc(1'b1, 1'b1, 15'd5, 1'b0, 32'h0);
    cyc(1'b0, 1'b0, 15'd6, 1'b0, 32'h0);
    cyc(1'b0, 1'b0, 15'd6, 1'b1, 32'h5555_AAAA);
    check_bank("R1");
    chk("R1", "cfg5 written", cfg_q[5*32 +: 32], 32'h5555_AAAA);
    chk("R1", "cfg6 kept", cfg_q[6*32 +: 32], 32'hA500_0006);
  endtask

  task automatic t_unimpl;
    cyc(1'b1, 1'b1, 15'(NREG), 1'b0, 32'h0);
    idle(1);
    cyc(1'b1, 1'b1, 15'h4001, 1'b1, 32'h7777_0008);
    check_bank("R7");
    idle(1);
    cyc(1'b1, 1'b1, 15'h0100, 1'b1, 32'h7777_4001);
    check_bank("R7");
    idle(1);
    cyc(1'b0, 1'b0, 15'h0, 1'b1, 32'h7777_0100);
    check_bank("R7");
  endtask

  task automatic t_read;
    cyc(1'b1, 1'b0, 15'd0, 1'b0, 32'h0);
    idle(1);
    cyc(1'b0, 1'b0, 15'h0, 1'b1, 32'h9999_9999);
    check_bank("R8");
    chk("R8", "cfg0 kept", cfg_q[31:0], 32'hA500_0000);
  endtask

  task automatic t_stray;
    idle(3);
    cyc(1'b0, 1'b1, 15'd7, 1'b1, 32'hBAD0_0007);
    cyc(1'b0, 1'b1, CTX_A, 1'b1, 32'hBAD0_4000);
    check_bank("R10");
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic        en;
      logic [14:0] a;
      en = (i % 2 == 0) && ($urandom % 4 != 0);
      case ($urandom % 4)
        0: a = {1'b0, 14'($urandom % (NREG + 2))};
        1: a = CTX_A;
        2: a = {1'b1, 14'($urandom % 3)};
        default: a = 15'($urandom);
      endcase
      cyc(en, 1'($urandom), a, 1'($urandom), $urandom);
      check_bank("R4");
    end
    idle(3);
  endtask

  initial begin
    rst_n = 1'b0;
    cp_en = 0; cp_wr = 0; cp_addr = '0; cp_commit = 0; cp_wdata = '0;
    p1_v = 0; p1_wr = 0; p1_a = '0; p2_v = 0; p2_wr = 0; p2_a = '0;
    for (int i = 0; i < NREG; i++) m_cfg[i] = '0;
    m_ctx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    t_reset();
    t_single();
    t_cancel();
    t_overlap();
    t_hold();
    t_unimpl();
    t_read();
    t_stray();
    t_random();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule